// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns characters written by a host into frames on a single serial output line. The host writes characters into a sixteen-entry queue through a write strobe, and a full flag tells it when the queue has no room. The transmitter takes the characters in the order they were written. Each frame has a low start bit, then the configured number of data bits sent least significant bit first, then an optional parity bit, and last a high stop period.

Static configuration inputs set the frame format: character length, whether parity is present, even or odd parity, and a stop period of one, one and a half or two bit times. Bit timing comes from a baud enable strobe, and each bit lasts sixteen strobes. When the queue still holds a character at the end of a stop period, the next frame starts at once, so a full queue goes out as one continuous stream. A write made while the queue is full is dropped, and a sticky flag records that this happened.

Top module: `serial_frame_tx`

## Requirements
- R1: When no frame is in progress, including after a burst has drained, txd is held high.
- R2: A frame begins with txd low for 16 baud ticks. The frame starts on the clock after the queue becomes non-empty while the line is idle.
- R3: After the start bit, the data bits follow least significant bit first, each held for 16 ticks. cfg_len codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits of wr_data above the selected length are not sent.
- R4: With cfg_par_en=1, one parity bit of 16 ticks follows the data. With cfg_par_odd=0 the count of ones over data plus parity is even, and with cfg_par_odd=1 it is odd.
- R5: With cfg_par_en=0, no parity bit is sent and the stop period follows the last data bit directly.
- R6: The stop period drives txd high for 16, 24 or 32 ticks when cfg_stop is 0, 1 or 2. Code 3 behaves like code 2.
- R7: If the queue is non-empty when a stop period ends, the next start bit begins on the very next tick, with no idle time between frames.
- R8: The queue holds 16 characters and sends them in write order. full is 1 exactly when 16 characters are waiting, and writes made during a frame are accepted while full is 0.
- R9: A write while full is 1 is dropped and never appears on txd. It sets overflow, which then stays 1 until reset.
- R10: After reset, txd is 1, full is 0 and overflow is 0.
- R11: Frame timing advances only on clock edges where tick is 1. Between ticks, txd does not change except when a frame starts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Baud enable strobe, 16 per bit time |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to be queued |
| cfg_len | input | 2 | Data length code: 0..3 selects 5..8 bits |
| cfg_par_en | input | 1 | 1 = append a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop | input | 2 | Stop length code: 0 = 16, 1 = 24, 2 or 3 = 32 ticks |
| full | output | 1 | Queue holds 16 characters |
| overflow | output | 1 | Sticky flag: a write was dropped |
| txd | output | 1 | Serial output line |

## Verification
Internal faults in this block show up on txd within a single frame. A wrong tick count makes a field the wrong length. A bit index that stops one step late or early adds or removes a data bit. A queue pointer slip sends a character twice or skips one, and that corrupts the frame right after the fault. A count that misses the full condition shows in two ways: full does not rise, and an extra character appears after the overflow burst.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_stop,
  output logic       full,
  output logic       overflow,
  output logic       txd
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(2 * OSR);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_t;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  state_t        state;
  logic [7:0]    sh;
  logic          par_b;
  logic [2:0]    bitn;
  logic [CW-1:0] tcnt;
  logic [CW-1:0] stop_last;
  logic [7:0]    mask;
  logic          push, pop, bit_end, stop_end, has_data;

  assign full     = (cnt == (AW+1)'(DEPTH));
  assign has_data = (cnt != '0);
  assign push     = wr_en && !full;
  assign mask     = 8'hFF >> (3'd3 - {1'b0, cfg_len});
  assign bit_end  = tick && (tcnt == CW'(OSR - 1));
  assign stop_end = tick && (tcnt == stop_last);
  assign pop      = has_data && (state == S_IDLE || (state == S_STOP && stop_end));

  always_comb begin
    case (cfg_stop)
      2'd0:    stop_last = CW'(OSR - 1);
      2'd1:    stop_last = CW'(OSR + OSR / 2 - 1);
      default: stop_last = CW'(2 * OSR - 1);
    endcase
  end

  always_comb begin
    case (state)
      S_START: txd = 1'b0;
      S_DATA:  txd = sh[0];
      S_PAR:   txd = par_b;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      if (wr_en && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sh    <= '0;
      par_b <= 1'b0;
      bitn  <= '0;
      tcnt  <= '0;
    end else begin
      if (pop) begin
        sh    <= mem[rp];
        par_b <= (^(mem[rp] & mask)) ^ cfg_par_odd;
        state <= S_START;
        tcnt  <= '0;
      end else begin
        case (state)
          S_START:
            if (bit_end) begin
              tcnt  <= '0;
              bitn  <= '0;
              state <= S_DATA;
            end else if (tick) tcnt <= tcnt + 1'b1;
          S_DATA:
            if (bit_end) begin
              tcnt <= '0;
              sh   <= sh >> 1;
              if (bitn == 3'(cfg_len) + 3'd4)
                state <= cfg_par_en ? S_PAR : S_STOP;
              else
                bitn <= bitn + 1'b1;
            end else if (tick) tcnt <= tcnt + 1'b1;
          S_PAR:
            if (bit_end) begin
              tcnt  <= '0;
              state <= S_STOP;
            end else if (tick) tcnt <= tcnt + 1'b1;
          S_STOP:
            if (stop_end) begin
              tcnt  <= '0;
              state <= S_IDLE;
            end else if (tick) tcnt <= tcnt + 1'b1;
          default: tcnt <= '0;
        endcase
      end
    end
  end

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));

  a_r9_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> overflow);

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

  a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && has_data) |=> !txd);

  a_r7_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && stop_end && has_data) |=> !txd);

  a_r11_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && state != S_IDLE) |=> $stable(txd));
endmodule

// File: tb/serial_frame_tx_test.sv
module serial_frame_tx_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] cfg_len = 0;
  logic       cfg_par_en = 0;
  logic       cfg_par_odd = 0;
  logic [1:0] cfg_stop = 0;
  logic       full, overflow, txd;

  int tests = 0;
  int fails = 0;
  logic [7:0] chars [0:31];
  int tdiv = 0;

  serial_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .full(full), .overflow(overflow), .txd(txd));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv + 1) % 2;
    tick <= (tdiv == 0);
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic sample(output logic v);
    do @(negedge clk); while (!tick);
    v = txd;
  endtask

  task automatic expect_run(input int n, input logic v, inout int bad);
    logic s;
    for (int i = 0; i < n; i++) begin
      sample(s);
      if (s !== v) bad++;
    end
  endtask

  task automatic monitor(input int nframes);
    logic s;
    int wait_n = 0;
    int bad;
    int len;
    int stop_t;
    logic [7:0] m;
    logic p;
    len = 5 + cfg_len;
    stop_t = (cfg_stop == 0) ? 16 : (cfg_stop == 1) ? 24 : 32;
    m = 8'hFF >> (8 - len);
    sample(s);
    while (s !== 1'b0 && wait_n < 400) begin
      wait_n++;
      sample(s);
    end
    chk(s === 1'b0, "R2 start bit seen", s, 0);
    for (int f = 0; f < nframes; f++) begin
      bad = 0;
      expect_run(f == 0 ? 15 : 16, 1'b0, bad);
      chk(bad == 0, f == 0 ? "R2 start bit low" : "R7 back-to-back start", bad, 0);
      bad = 0;
      for (int b = 0; b < len; b++) expect_run(16, chars[f][b], bad);
      chk(bad == 0, "R3 R11 data bits lsb first", bad, 0);
      if (cfg_par_en) begin
        p = (^(chars[f] & m)) ^ cfg_par_odd;
        bad = 0;
        expect_run(16, p, bad);
        chk(bad == 0, "R4 parity bit", bad, 0);
      end
      bad = 0;
      expect_run(stop_t, 1'b1, bad);
      chk(bad == 0, cfg_par_en ? "R6 stop period" : "R5 R6 no parity then stop", bad, 0);
    end
    bad = 0;
    expect_run(40, 1'b1, bad);
    chk(bad == 0, "R1 R9 idle mark after burst", bad, 0);
  endtask

  task automatic write_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1;
      wr_data = chars[i];
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd === 1'b1, "R10 txd after reset", txd, 1);
    chk(full === 1'b0, "R10 full after reset", full, 0);
    chk(overflow === 1'b0, "R10 overflow after reset", overflow, 0);

    for (int l = 0; l < 4; l++)
      for (int pe = 0; pe < 2; pe++)
        for (int po = 0; po < 2; po++)
          for (int st = 0; st < 4; st++) begin
            if (st == 3 && (l + pe + po) % 2 == 1) continue;
            cfg_len = 2'(l);
            cfg_par_en = pe[0];
            cfg_par_odd = po[0];
            cfg_stop = 2'(st);
            chars[0] = 8'hA5 ^ 8'(l * 16 + st);
            chars[1] = 8'h3C + 8'(pe * 37 + po * 11);
            chars[2] = 8'hE1 ^ 8'(st * 5 + l);
            fork
              write_burst(3);
              monitor(3);
            join
          end

    cfg_len = 2'd3;
    cfg_par_en = 0;
    cfg_par_odd = 0;
    cfg_stop = 2'd0;
    for (int i = 0; i < 17; i++) chars[i] = 8'h10 + 8'(i * 7);
    fork
      begin
        write_burst(17);
        chk(full === 1'b1, "R8 full with 16 queued", full, 1);
        chk(overflow === 1'b0, "R9 no overflow yet", overflow, 0);
        wr_en = 1;
        wr_data = 8'hEE;
        @(negedge clk);
        wr_en = 0;
        chk(overflow === 1'b1, "R9 overflow set", overflow, 1);
        repeat (50) @(negedge clk);
        chk(overflow === 1'b1, "R9 overflow sticky", overflow, 1);
      end
      monitor(17);
    join
    chk(full === 1'b0, "R8 full clears after drain", full, 0);
    chk(overflow === 1'b1, "R9 overflow still set", overflow, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule